// File: doc/BRIEF.md
# Vector Length Configuration Unit

This block holds the vector configuration state: the current vector length and the type word, which has an element-width code, a group-multiplier code and an illegal flag. It executes vector configuration instructions. Each request supplies a width code, a multiplier code, an application vector length, and two flags that say whether the source and destination registers are x0. In the same cycle the block returns the length to write back to the destination register and a precise trap request. The state updates on the next clock edge only when the request is valid and does not trap.

The multiplier code is ordered by maximum vector length (VLMAX). Codes 0 to 3 are the fractions 1/16, 1/8, 1/4 and 1/2. Codes 4 to 7 are the whole values 1, 2, 4 and 8. A request cannot ask for 1/16 directly: code 0 asks the block to derive the multiplier from the current state so that the width-to-multiplier ratio stays the same. A derived result of 0 is still stored, and it means 1/16. Element width is 8 << width code. VLEN, ELEN and XLEN are parameters.

Top module: `vcfg_unit`

## Requirements
- R1: After reset the illegal flag is 1, and the length, width code and multiplier code are all 0.
- R2: For a legal request, VLMAX = (VLEN >> (3 + width code)) scaled by the multiplier: codes 4 to 7 multiply by 1, 2, 4 and 8. The new length is min(requested length, VLMAX). It appears on rd_wdata in the request cycle and is stored, with the width and multiplier codes, on the next edge.
- R3: Multiplier codes 3, 2 and 1 divide VLEN >> (3 + width code) by 2, 4 and 8, and a stored code 0 divides it by 16.
- R4: When the source is x0 and the destination is not, the new length is VLMAX and the requested length is ignored.
- R5: A request is illegal when 8 << width code exceeds ELEN or when VLMAX comes out as 0. It raises no trap. It stores illegal flag 1, width code 0, multiplier code 0 and length 0, and rd_wdata is 0.
- R6: Multiplier code 0 in a request derives the stored code as new width code - old width code + old multiplier code. The ratio of width to multiplier is kept, and a derived 0 is stored and read back as 0.
- R7: A derivation request made while the stored illegal flag is 1 raises a trap.
- R8: A derivation whose result lies outside 0..7 raises a trap.
- R9: When both source and destination are x0, the current length is the requested length. A trap is raised when the new VLMAX differs from the current one; an illegal configuration counts as VLMAX 0 on either side of this comparison.
- R10: A trap leaves the length and the type fields unchanged. The trap output is 0 when no valid request is present, and the state does not change then.
- R11: The group-count output gives 32 for stored multiplier codes 0 to 4, and 16, 8 and 4 for codes 5, 6 and 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_valid | input | 1 | A configuration request is present this cycle |
| req_vsew | input | 3 | Requested element-width code |
| req_vlmul | input | 3 | Requested multiplier code, 0 = derive |
| req_avl | input | XLEN | Application vector length |
| rs1_is_x0 | input | 1 | Source register is x0 |
| rd_is_x0 | input | 1 | Destination register is x0 |
| rd_wdata | output | XLEN | New length for the destination register |
| cfg_trap | output | 1 | Precise trap request |
| vl_out | output | $clog2(VLEN)+1 | Stored vector length |
| vtype_vill | output | 1 | Stored illegal flag |
| vtype_vsew | output | 3 | Stored element-width code |
| vtype_vlmul | output | 3 | Stored multiplier code |
| reg_groups | output | 6 | Number of usable register groups |

## Verification
The assertions assume that the request fields are stable and defined whenever cfg_valid is high. They also assume that, with the default parameters, the stored length never exceeds the stored VLMAX, which holds because only the block writes the state. The stimulus drives every request on the falling clock edge and holds it through the next rising edge, then drops cfg_valid. Each request uses only width codes and lengths whose VLMAX the bench computes directly from R2 and R3.

// File: rtl/vcfg_pkg.sv
package vcfg_pkg;

  typedef struct packed {
    logic       vill;
    logic [2:0] vsew;
    logic [2:0] vlmul;
  } vtype_t;

  localparam logic [2:0] LMUL_DERIVE = 3'b000;

  // Register groups available for a stored multiplier code.
  function automatic logic [5:0] group_count(input logic [2:0] code);
    logic [5:0] n;
    case (code)
      3'd5:    n = 6'd16;
      3'd6:    n = 6'd8;
      3'd7:    n = 6'd4;
      default: n = 6'd32;
    endcase
    return n;
  endfunction

endpackage

// File: rtl/vcfg_lmul_derive.sv
module vcfg_lmul_derive
  import vcfg_pkg::*;
(
  input  logic [2:0] req_vsew,
  input  logic [2:0] req_vlmul,
  input  vtype_t     old_vtype,
  output logic       derive_req,
  output logic [2:0] eff_vlmul,
  output logic       derive_fault
);

  logic [4:0] sum;

  always_comb begin
    derive_req = (req_vlmul == LMUL_DERIVE);
    // Five-bit two's complement: the range is -7..14, so bits 4:3 flag out of range.
    sum = {2'b00, req_vsew} - {2'b00, old_vtype.vsew} + {2'b00, old_vtype.vlmul};
    if (derive_req) begin
      eff_vlmul    = sum[2:0];
      derive_fault = old_vtype.vill || (sum[4:3] != 2'b00);
    end else begin
      eff_vlmul    = req_vlmul;
      derive_fault = 1'b0;
    end
  end

endmodule

// File: rtl/vcfg_vlmax_calc.sv
module vcfg_vlmax_calc #(
  parameter int VLEN = 128,
  parameter int ELEN = 64,
  parameter int VLW  = $clog2(VLEN) + 1
) (
  input  logic [2:0]     vsew,
  input  logic [2:0]     vlmul,
  output logic           legal,
  output logic [VLW-1:0] vlmax
);

  localparam int             MAX_VSEW = $clog2(ELEN / 8);
  localparam logic [VLW-1:0] VLEN_V   = VLW'(VLEN);

  logic [VLW-1:0] base;
  logic           sew_ok;

  always_comb begin
    base = VLEN_V >> (4'd3 + {1'b0, vsew});
    if (vlmul[2]) vlmax = base << vlmul[1:0];
    else          vlmax = base >> (3'd4 - {1'b0, vlmul[1:0]});
    sew_ok = (int'(vsew) <= MAX_VSEW);
    legal  = sew_ok && (vlmax != '0);
  end

endmodule

// File: rtl/vcfg_state.sv
module vcfg_state
  import vcfg_pkg::*;
#(
  parameter int VLW = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           upd_en,
  input  logic [VLW-1:0] vl_d,
  input  vtype_t         vtype_d,
  output logic [VLW-1:0] vl_q,
  output vtype_t         vtype_q
);

  logic [VLW-1:0] vl_n;
  vtype_t         vtype_n;

  always_comb begin
    vl_n    = vl_q;
    vtype_n = vtype_q;
    if (upd_en) begin
      vl_n    = vl_d;
      vtype_n = vtype_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vl_q    <= '0;
      vtype_q <= '{vill: 1'b1, vsew: 3'd0, vlmul: 3'd0};
    end else begin
      vl_q    <= vl_n;
      vtype_q <= vtype_n;
    end
  end

endmodule

// File: rtl/vcfg_unit.sv
module vcfg_unit
  import vcfg_pkg::*;
#(
  parameter int VLEN = 128,
  parameter int ELEN = 64,
  parameter int XLEN = 32,
  localparam int VLW = $clog2(VLEN) + 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_valid,
  input  logic [2:0]      req_vsew,
  input  logic [2:0]      req_vlmul,
  input  logic [XLEN-1:0] req_avl,
  input  logic            rs1_is_x0,
  input  logic            rd_is_x0,
  output logic [XLEN-1:0] rd_wdata,
  output logic            cfg_trap,
  output logic [VLW-1:0]  vl_out,
  output logic            vtype_vill,
  output logic [2:0]      vtype_vsew,
  output logic [2:0]      vtype_vlmul,
  output logic [5:0]      reg_groups
);

  vtype_t         cur_vtype;
  vtype_t         new_vtype;
  logic [VLW-1:0] cur_vl;
  logic [VLW-1:0] new_vl;

  logic           derive_req;
  logic [2:0]     eff_vlmul;
  logic           derive_fault;

  logic           new_legal, cur_legal;
  logic [VLW-1:0] new_vlmax, cur_vlmax;
  logic [VLW-1:0] new_vlmax_eff, cur_vlmax_eff;
  logic [XLEN-1:0] avl_sel;
  logic           ratio_fault;
  logic           upd_en;

  vcfg_lmul_derive u_derive (
    .req_vsew    (req_vsew),
    .req_vlmul   (req_vlmul),
    .old_vtype   (cur_vtype),
    .derive_req  (derive_req),
    .eff_vlmul   (eff_vlmul),
    .derive_fault(derive_fault)
  );

  vcfg_vlmax_calc #(.VLEN(VLEN), .ELEN(ELEN), .VLW(VLW)) u_new_vlmax (
    .vsew (req_vsew),
    .vlmul(eff_vlmul),
    .legal(new_legal),
    .vlmax(new_vlmax)
  );

  vcfg_vlmax_calc #(.VLEN(VLEN), .ELEN(ELEN), .VLW(VLW)) u_cur_vlmax (
    .vsew (cur_vtype.vsew),
    .vlmul(cur_vtype.vlmul),
    .legal(cur_legal),
    .vlmax(cur_vlmax)
  );

  always_comb begin
    new_vlmax_eff = new_legal ? new_vlmax : '0;
    cur_vlmax_eff = (cur_legal && !cur_vtype.vill) ? cur_vlmax : '0;

    avl_sel = (rs1_is_x0 && rd_is_x0) ? XLEN'(cur_vl) : req_avl;

    if (!new_legal)
      new_vl = '0;
    else if (rs1_is_x0 && !rd_is_x0)
      new_vl = new_vlmax;
    else if (avl_sel < XLEN'(new_vlmax))
      new_vl = VLW'(avl_sel);
    else
      new_vl = new_vlmax;

    if (new_legal) new_vtype = '{vill: 1'b0, vsew: req_vsew, vlmul: eff_vlmul};
    else           new_vtype = '{vill: 1'b1, vsew: 3'd0, vlmul: 3'd0};

    ratio_fault = rs1_is_x0 && rd_is_x0 && (new_vlmax_eff != cur_vlmax_eff);
    cfg_trap    = cfg_valid && (derive_fault || ratio_fault);
    upd_en      = cfg_valid && !cfg_trap;
    rd_wdata    = XLEN'(new_vl);
  end

  vcfg_state #(.VLW(VLW)) u_state (
    .clk    (clk),
    .rst_n  (rst_n),
    .upd_en (upd_en),
    .vl_d   (new_vl),
    .vtype_d(new_vtype),
    .vl_q   (cur_vl),
    .vtype_q(cur_vtype)
  );

  assign vl_out      = cur_vl;
  assign vtype_vill  = cur_vtype.vill;
  assign vtype_vsew  = cur_vtype.vsew;
  assign vtype_vlmul = cur_vtype.vlmul;
  assign reg_groups  = group_count(cur_vtype.vlmul);

  // R10: a trapping request leaves the architectural state untouched
  a_r10_trap_keeps_state: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_valid && cfg_trap) |=> ($stable(cur_vl) && $stable(cur_vtype)));

  // R5: the illegal flag comes with all other fields cleared
  a_r5_vill_clears_fields: assert property (@(posedge clk) disable iff (!rst_n)
    cur_vtype.vill |-> (cur_vtype.vsew == 3'd0 && cur_vtype.vlmul == 3'd0 && cur_vl == '0));

  // R2: the stored length never exceeds the stored VLMAX
  a_r2_vl_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    !cur_vtype.vill |-> (cur_vl <= cur_vlmax));

  // R2: the write-back length never exceeds a length given in a register
  a_r2_rd_le_avl: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_valid && !cfg_trap && !rs1_is_x0) |-> (rd_wdata <= req_avl));

  // R6: derivation keeps the width-to-multiplier ratio
  a_r6_ratio_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_valid && !cfg_trap && req_vlmul == LMUL_DERIVE) |=>
      (cur_vtype.vill ||
       ({1'b0, cur_vtype.vlmul} + $past({1'b0, cur_vtype.vsew}) ==
        {1'b0, cur_vtype.vsew} + $past({1'b0, cur_vtype.vlmul}))));

  // R7: derivation on an illegal state always traps
  a_r7_trap_on_vill: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_valid && req_vlmul == LMUL_DERIVE && cur_vtype.vill) |-> cfg_trap);

  // R9: a non-trapping x0/x0 request keeps the length
  a_r9_vl_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_valid && !cfg_trap && rs1_is_x0 && rd_is_x0) |=> (cur_vl == $past(cur_vl)));

  // R10: no trap without a request
  a_r10_no_idle_trap: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_valid |-> !cfg_trap);

endmodule

// File: tb/vcfg_unit_test.sv
`timescale 1ns/1ps
module vcfg_unit_test;

  localparam int XLEN = 32;
  localparam int VLW  = 8;

  logic            clk = 1'b0;
  logic            rst_n;
  logic            cfg_valid;
  logic [2:0]      req_vsew;
  logic [2:0]      req_vlmul;
  logic [XLEN-1:0] req_avl;
  logic            rs1_is_x0;
  logic            rd_is_x0;
  logic [XLEN-1:0] rd_wdata;
  logic            cfg_trap;
  logic [VLW-1:0]  vl_out;
  logic            vtype_vill;
  logic [2:0]      vtype_vsew;
  logic [2:0]      vtype_vlmul;
  logic [5:0]      reg_groups;

  int nchecks = 0;
  int nerrors = 0;

  always #4 clk = ~clk;

  vcfg_unit #(.VLEN(128), .ELEN(64), .XLEN(XLEN)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_valid(cfg_valid),
    .req_vsew(req_vsew), .req_vlmul(req_vlmul), .req_avl(req_avl),
    .rs1_is_x0(rs1_is_x0), .rd_is_x0(rd_is_x0),
    .rd_wdata(rd_wdata), .cfg_trap(cfg_trap), .vl_out(vl_out),
    .vtype_vill(vtype_vill), .vtype_vsew(vtype_vsew),
    .vtype_vlmul(vtype_vlmul), .reg_groups(reg_groups)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    nchecks++;
    if (act != exp) begin
      nerrors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic chk_state(input string req, input int vill, input int vsew,
                           input int vlmul, input int vl);
    chk(req, "vill", int'(vtype_vill), vill);
    chk(req, "vsew", int'(vtype_vsew), vsew);
    chk(req, "vlmul", int'(vtype_vlmul), vlmul);
    chk(req, "vl", int'(vl_out), vl);
  endtask

  // Drive one request on the falling edge, check the combinational result,
  // let the rising edge update the state, then check the state.
  // exp_rd < 0 means the write-back value is not checked.
  task automatic issue(input string req, input int vsew, input int vlmul, input int avl,
                       input bit s_x0, input bit d_x0, input int exp_trap, input int exp_rd,
                       input int e_vill, input int e_vsew, input int e_vlmul, input int e_vl);
    @(negedge clk);
    cfg_valid = 1'b1;
    req_vsew  = 3'(vsew);
    req_vlmul = 3'(vlmul);
    req_avl   = XLEN'(avl);
    rs1_is_x0 = s_x0;
    rd_is_x0  = d_x0;
    #1;
    chk(req, "trap", int'(cfg_trap), exp_trap);
    if (exp_rd >= 0) chk(req, "rd_wdata", int'(rd_wdata), exp_rd);
    @(posedge clk);
    #1;
    cfg_valid = 1'b0;
    chk_state(req, e_vill, e_vsew, e_vlmul, e_vl);
  endtask

  task automatic t_reset;
    chk_state("R1", 1, 0, 0, 0);
  endtask

  task automatic t_whole;
    issue("R2", 2, 4, 3, 0, 0, 0, 3, 0, 2, 4, 3);
    issue("R2", 2, 4, 100, 0, 0, 0, 4, 0, 2, 4, 4);
    issue("R2", 0, 7, 200, 0, 0, 0, 128, 0, 0, 7, 128);
    chk("R11", "groups m8", int'(reg_groups), 4);
    issue("R2", 1, 6, 5, 0, 0, 0, 5, 0, 1, 6, 5);
    chk("R11", "groups m4", int'(reg_groups), 8);
    issue("R2", 3, 5, 40, 0, 0, 0, 4, 0, 3, 5, 4);
    chk("R11", "groups m2", int'(reg_groups), 16);
  endtask

  task automatic t_frac;
    issue("R3", 0, 3, 20, 0, 0, 0, 8, 0, 0, 3, 8);
    chk("R11", "groups frac", int'(reg_groups), 32);
    issue("R3", 1, 1, 5, 0, 0, 0, 1, 0, 1, 1, 1);
    issue("R3", 0, 2, 3, 0, 0, 0, 3, 0, 0, 2, 3);
  endtask

  task automatic t_take_vlmax;
    issue("R4", 1, 5, 7, 1, 0, 0, 16, 0, 1, 5, 16);
  endtask

  task automatic t_illegal;
    issue("R5", 3, 2, 9, 0, 0, 0, 0, 1, 0, 0, 0);
    issue("R2", 0, 4, 9, 0, 0, 0, 9, 0, 0, 4, 9);
    issue("R5", 4, 4, 9, 0, 0, 0, 0, 1, 0, 0, 0);
  endtask

  task automatic t_derive;
    issue("R6", 2, 4, 100, 0, 0, 0, 4, 0, 2, 4, 4);
    issue("R6", 0, 0, 100, 0, 0, 0, 4, 0, 0, 2, 4);
    issue("R6", 3, 0, 100, 0, 0, 0, 4, 0, 3, 5, 4);
    issue("R6", 1, 1, 5, 0, 0, 0, 1, 0, 1, 1, 1);
    issue("R6", 0, 0, 5, 0, 0, 0, 1, 0, 0, 0, 1);
    chk("R11", "groups 1/16", int'(reg_groups), 32);
  endtask

  task automatic t_trap_vill;
    issue("R5", 4, 4, 1, 0, 0, 0, 0, 1, 0, 0, 0);
    issue("R7", 0, 0, 5, 0, 0, 1, -1, 1, 0, 0, 0);
  endtask

  task automatic t_trap_range;
    issue("R2", 0, 7, 200, 0, 0, 0, 128, 0, 0, 7, 128);
    issue("R8", 3, 0, 9, 0, 0, 1, -1, 0, 0, 7, 128);
  endtask

  task automatic t_x0x0;
    issue("R2", 2, 4, 3, 0, 0, 0, 3, 0, 2, 4, 3);
    issue("R9", 1, 3, 999, 1, 1, 0, 3, 0, 1, 3, 3);
    issue("R9", 0, 4, 0, 1, 1, 1, -1, 0, 1, 3, 3);
    issue("R10", 0, 4, 50, 1, 1, 1, -1, 0, 1, 3, 3);
  endtask

  task automatic t_idle;
    @(negedge clk);
    cfg_valid = 1'b0;
    req_vsew  = 3'd0;
    req_vlmul = 3'd7;
    req_avl   = 32'd77;
    rs1_is_x0 = 1'b1;
    rd_is_x0  = 1'b1;
    #1;
    chk("R10", "idle trap", int'(cfg_trap), 0);
    @(posedge clk);
    #1;
    chk_state("R10", 0, 1, 3, 3);
  endtask

  initial begin
    #(8 * 100000);
    nerrors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", nchecks, nerrors);
    $finish;
  end

  initial begin
    rst_n     = 1'b0;
    cfg_valid = 1'b0;
    req_vsew  = '0;
    req_vlmul = '0;
    req_avl   = '0;
    rs1_is_x0 = 1'b0;
    rd_is_x0  = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    t_reset();
    t_whole();
    t_frac();
    t_take_vlmax();
    t_illegal();
    t_derive();
    t_trap_vill();
    t_trap_range();
    t_x0x0();
    t_idle();
    $display("Simulation finished: %0d checks, %0d errors", nchecks, nerrors);
    $finish;
  end

endmodule